// File: doc/BRIEF.md
# Adaptive Redundancy Mode Controller

This block decides how a bank of reconfigurable processing regions is used. It chooses among five operating modes. Two are performance modes, in which every region holds an accelerator: one with the accelerators alone and one that also runs a second processor. The other three are lockstep modes with one, two or three regions acting as processors. The decision comes from a count of configuration upsets seen over a sliding time window. The count is held against an upper and a lower programmable limit, and the mode moves one level up or down at a time.

A ground command can also force any legal mode for a given number of cycles. While that timer runs, the count does not drive the mode. When a switch changes the role of any region, the block raises a request for each such region and holds the new mode as pending until every one of those regions reports done. When the switch adds lockstep processors, the block pulses a one-cycle reset of the lockstep group so that the processors start in step. All pins are plain control and status levels or pulses. The block has no streaming interface, so there is no back-pressure.

Top module: `redund_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `mode_o` is 0, and `reconf_req_o`, `lockstep_rst_o`, `switch_busy_o` and `ovr_active_o` are all 0.
- R2: The mode codes are 0 for accelerators only, 1 for accelerators with a second processor, 2 for simplex, 3 for duplex and 4 for triplex. Region i acts as a processor when i is less than the lockstep count, which is 0, 0, 1, 2 and 3 for the codes 0 to 4. Bit i of `reconf_req_o` and of `reconf_done_i` belongs to region i. `mode_o` never exceeds 4.
- R3: The window is made of NUM_BUCKETS buckets, each `bucket_len_i` cycles long. An upset is counted from the cycle after its pulse until between (NUM_BUCKETS-1) and NUM_BUCKETS bucket lengths later.
- R4: When the window count is strictly greater than `thr_hi_i` and the mode is below 4, the mode steps up one code. A count equal to `thr_hi_i` changes nothing.
- R5: When the window count is strictly below `thr_lo_i` and the mode is above 0, the mode steps down one code. A count from `thr_lo_i` to `thr_hi_i` leaves the mode unchanged.
- R6: A switch raises `reconf_req_o` for exactly the regions whose role differs between the old mode and the new one. A switch that changes no region's role updates `mode_o` on the clock edge after the trigger and raises no request.
- R7: Each request bit stays high until its region's done bit is seen. The mode takes the pending value on the edge at which the last outstanding done bit is seen. No request bit rises while a switch is pending.
- R8: While `switch_busy_o` is high, the mode does not change, and threshold crossings and override commands are ignored.
- R9: When a switch raises the lockstep count, `lockstep_rst_o` is high for exactly one cycle, in the cycle the new mode first appears.
- R10: When a switch lowers the lockstep count or leaves it the same, `lockstep_rst_o` stays low.
- R11: An override pulse on `ovr_valid_i` with a code of 4 or less, taken while no switch is pending, forces that mode and suppresses the threshold policy for `ovr_cycles_i` cycles, with `ovr_active_o` high. A code above 4 is ignored.
- R12: When the override time runs out, the threshold policy resumes from the current mode using the current window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upset_i | input | 1 | One pulse per configuration upset |
| bucket_len_i | input | TIME_W | Length of one window bucket in cycles |
| thr_hi_i | input | CNT_W | Escalation limit (count must exceed it) |
| thr_lo_i | input | CNT_W | De-escalation limit (count must be below it) |
| ovr_valid_i | input | 1 | Override command strobe |
| ovr_mode_i | input | 3 | Mode forced by the override |
| ovr_cycles_i | input | TIME_W | Override duration in cycles |
| reconf_done_i | input | NUM_REGIONS | Per-region reconfiguration complete |
| mode_o | output | 3 | Current mode |
| reconf_req_o | output | NUM_REGIONS | Per-region reconfiguration request |
| lockstep_rst_o | output | 1 | One-cycle resynchronising reset of the lockstep group |
| switch_busy_o | output | 1 | A switch is pending |
| ovr_active_o | output | 1 | An override is in force |

## Verification
Upsets are applied as a burst that stops exactly at the upper limit and then goes one past it. This separates a strict comparison from an inclusive one, and once over the limit the mode climbs to triplex and decays back to the bottom after the upsets leave the window. Two overrides are used. The first, a jump straight to triplex with done bits returned one region at a time and a second command issued while busy, tells whole-mask commits from per-bit commits and shows whether triggers during a pending switch are dropped. The second, a short override that holds a low mode while upsets arrive, shows that the threshold policy is suppressed and then resumes with the stored count. A transition scoreboard on mode, requests and reset reports any output change that was not expected, so a reset pulse on a downward switch or a request for an unchanged region is caught.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef logic [2:0] rmc_mode_t;

  localparam rmc_mode_t MODE_ACCEL   = 3'd0;
  localparam rmc_mode_t MODE_DUALCPU = 3'd1;
  localparam rmc_mode_t MODE_SIMPLEX = 3'd2;
  localparam rmc_mode_t MODE_DUPLEX  = 3'd3;
  localparam rmc_mode_t MODE_TRIPLEX = 3'd4;

  // number of regions acting as lockstep processors in a mode
  function automatic logic [2:0] lanes_of(input rmc_mode_t m);
    if (m >= MODE_SIMPLEX && m <= MODE_TRIPLEX) return m - 3'd1;
    return 3'd0;
  endfunction
endpackage

// File: rtl/rmc_upset_window.sv
module rmc_upset_window
  import rmc_pkg::*;
#(
  parameter int NUM_BUCKETS = 4,
  parameter int CNT_W       = 8,
  parameter int TIME_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upset_i,
  input  logic [TIME_W-1:0] bucket_len_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int HIST  = NUM_BUCKETS - 1;
  localparam int SUM_W = CNT_W + $clog2(NUM_BUCKETS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TIME_W-1:0] tmr_q;
  logic [CNT_W-1:0]  live_q;
  logic [CNT_W-1:0]  live_nxt;
  logic [CNT_W-1:0]  hist_q [HIST];
  logic              tick;
  logic [SUM_W-1:0]  sum;

  assign tick     = (bucket_len_i <= 1) || (tmr_q >= bucket_len_i - 1'b1);
  assign live_nxt = (upset_i && live_q != CNT_MAX) ? live_q + 1'b1 : live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      live_q <= '0;
    end else if (tick) begin
      tmr_q  <= '0;
      live_q <= '0;
    end else begin
      tmr_q  <= tmr_q + 1'b1;
      live_q <= live_nxt;
    end
  end

  generate
    for (genvar g = 0; g < HIST; g++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hist_q[g] <= '0;
        else if (tick) hist_q[g] <= (g == 0) ? live_nxt : hist_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_comb begin
    sum = SUM_W'(live_q);
    for (int i = 0; i < HIST; i++) sum = sum + SUM_W'(hist_q[i]);
  end

  assign count_o = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
endmodule

// File: rtl/rmc_ovr_timer.sv
module rmc_ovr_timer
  import rmc_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  rmc_mode_t         mode_i,
  input  logic [TIME_W-1:0] dur_i,
  output logic              active_o,
  output rmc_mode_t         mode_o
);
  logic [TIME_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      mode_o   <= MODE_ACCEL;
    end else if (load_i) begin
      remain_q <= dur_i;
      mode_o   <= mode_i;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign active_o = (remain_q != '0);
endmodule

// File: rtl/rmc_switch_seq.sv
module rmc_switch_seq
  import rmc_pkg::*;
#(
  parameter int NUM_REGIONS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  rmc_mode_t              target_i,
  input  logic [NUM_REGIONS-1:0] done_i,
  output rmc_mode_t              mode_o,
  output logic [NUM_REGIONS-1:0] req_o,
  output logic                   busy_o,
  output logic                   rst_o
);
  function automatic logic [NUM_REGIONS-1:0] role_mask(input rmc_mode_t m);
    logic [NUM_REGIONS-1:0] r;
    for (int i = 0; i < NUM_REGIONS; i++) r[i] = (i < int'(lanes_of(m)));
    return r;
  endfunction

  logic [NUM_REGIONS-1:0] outst_q, left, diff;
  rmc_mode_t              pend_q;

  assign diff   = role_mask(mode_o) ^ role_mask(target_i);
  assign left   = outst_q & ~done_i;
  assign req_o  = outst_q;
  assign busy_o = |outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o  <= MODE_ACCEL;
      pend_q  <= MODE_ACCEL;
      outst_q <= '0;
      rst_o   <= 1'b0;
    end else begin
      rst_o <= 1'b0;
      if (busy_o) begin
        outst_q <= left;
        if (left == '0) begin
          mode_o <= pend_q;
          rst_o  <= lanes_of(pend_q) > lanes_of(mode_o);
        end
      end else if (start_i) begin
        if (diff == '0) begin
          mode_o <= target_i;
          rst_o  <= lanes_of(target_i) > lanes_of(mode_o);
        end else begin
          outst_q <= diff;
          pend_q  <= target_i;
        end
      end
    end
  end
endmodule

// File: rtl/redund_mode_ctrl.sv
module redund_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int NUM_REGIONS = 3,
  parameter int NUM_BUCKETS = 4,
  parameter int CNT_W       = 8,
  parameter int TIME_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upset_i,
  input  logic [TIME_W-1:0]      bucket_len_i,
  input  logic [CNT_W-1:0]       thr_hi_i,
  input  logic [CNT_W-1:0]       thr_lo_i,
  input  logic                   ovr_valid_i,
  input  logic [2:0]             ovr_mode_i,
  input  logic [TIME_W-1:0]      ovr_cycles_i,
  input  logic [NUM_REGIONS-1:0] reconf_done_i,
  output logic [2:0]             mode_o,
  output logic [NUM_REGIONS-1:0] reconf_req_o,
  output logic                   lockstep_rst_o,
  output logic                   switch_busy_o,
  output logic                   ovr_active_o
);
  logic [CNT_W-1:0] win_cnt;
  rmc_mode_t        ovr_mode_q, target;
  logic             ovr_fire, start;

  rmc_upset_window #(.NUM_BUCKETS(NUM_BUCKETS), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_win (
    .clk(clk), .rst_n(rst_n), .upset_i(upset_i),
    .bucket_len_i(bucket_len_i), .count_o(win_cnt)
  );

  assign ovr_fire = ovr_valid_i && (ovr_mode_i <= MODE_TRIPLEX) && !switch_busy_o;

  rmc_ovr_timer #(.TIME_W(TIME_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .load_i(ovr_fire), .mode_i(ovr_mode_i),
    .dur_i(ovr_cycles_i), .active_o(ovr_active_o), .mode_o(ovr_mode_q)
  );

  always_comb begin
    target = mode_o;
    if (ovr_active_o)                                  target = ovr_mode_q;
    else if (win_cnt > thr_hi_i && mode_o != MODE_TRIPLEX) target = mode_o + 3'd1;
    else if (win_cnt < thr_lo_i && mode_o != MODE_ACCEL)   target = mode_o - 3'd1;
  end

  assign start = !ovr_fire && (target != mode_o);

  rmc_switch_seq #(.NUM_REGIONS(NUM_REGIONS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
    .done_i(reconf_done_i), .mode_o(mode_o), .req_o(reconf_req_o),
    .busy_o(switch_busy_o), .rst_o(lockstep_rst_o)
  );
endmodule

// File: rtl/redund_mode_ctrl_chk.sv
module redund_mode_ctrl_chk
  import rmc_pkg::*;
#(
  parameter int NUM_REGIONS = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             mode_o,
  input logic [NUM_REGIONS-1:0] reconf_req_o,
  input logic                   lockstep_rst_o,
  input logic                   switch_busy_o
);
  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= MODE_TRIPLEX); // R2

  AST_MODE_HELD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(switch_busy_o) && switch_busy_o) |-> $stable(mode_o)); // R8

  AST_REQ_NO_NEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(switch_busy_o) |-> ((reconf_req_o & ~$past(reconf_req_o)) == '0)); // R7

  AST_RST_ONLY_ON_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    lockstep_rst_o |-> (lanes_of(mode_o) > lanes_of($past(mode_o)))); // R9

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lockstep_rst_o |=> !lockstep_rst_o); // R9

  AST_NO_RST_ON_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != $past(mode_o)) && (lanes_of(mode_o) <= lanes_of($past(mode_o))))
      |-> !lockstep_rst_o); // R10
endmodule

bind redund_mode_ctrl redund_mode_ctrl_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .reconf_req_o(reconf_req_o),
  .lockstep_rst_o(lockstep_rst_o), .switch_busy_o(switch_busy_o)
);

// File: tb/redund_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module redund_mode_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upset = 1'b0;
  logic [15:0] bucket_len = 16'd50;
  logic [7:0]  thr_hi = 8'd3, thr_lo = 8'd1;
  logic        ovr_valid = 1'b0;
  logic [2:0]  ovr_mode = 3'd0;
  logic [15:0] ovr_cycles = 16'd0;
  logic [2:0]  auto_done = 3'b0, man_done = 3'b0, done;
  logic [2:0]  mode, req;
  logic        lrst, busy, ovr_act;
  logic        auto_en = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic [6:0]  exp_q[$];

  always #2 clk = ~clk;
  assign done = auto_done | man_done;

  redund_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .upset_i(upset), .bucket_len_i(bucket_len),
    .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .ovr_valid_i(ovr_valid),
    .ovr_mode_i(ovr_mode), .ovr_cycles_i(ovr_cycles), .reconf_done_i(done),
    .mode_o(mode), .reconf_req_o(req), .lockstep_rst_o(lrst),
    .switch_busy_o(busy), .ovr_active_o(ovr_act)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_t(input logic [2:0] m, input logic [2:0] r, input logic s);
    exp_q.push_back({m, r, s});
  endtask

  // escalation from mode m0 up to triplex while the count stays high
  task automatic push_up(input int m0);
    if (m0 == 0) expect_t(3'd1, 3'b000, 1'b0);
    if (m0 <= 1) begin expect_t(3'd1, 3'b001, 1'b0); expect_t(3'd2, 3'b000, 1'b1); end
    expect_t(3'd2, 3'b010, 1'b0); expect_t(3'd3, 3'b000, 1'b1);
    expect_t(3'd3, 3'b100, 1'b0); expect_t(3'd4, 3'b000, 1'b1);
    expect_t(3'd4, 3'b000, 1'b0);
  endtask

  // de-escalation from triplex to mode 0: no reset pulses anywhere (R10)
  task automatic push_down();
    expect_t(3'd4, 3'b100, 1'b0); expect_t(3'd3, 3'b000, 1'b0);
    expect_t(3'd3, 3'b010, 1'b0); expect_t(3'd2, 3'b000, 1'b0);
    expect_t(3'd2, 3'b001, 1'b0); expect_t(3'd1, 3'b000, 1'b0);
    expect_t(3'd0, 3'b000, 1'b0);
  endtask

  task automatic pulse_upset();
    @(negedge clk); upset = 1'b1;
    @(negedge clk); upset = 1'b0;
  endtask

  task automatic send_ovr(input logic [2:0] m, input logic [15:0] d);
    @(negedge clk); ovr_valid = 1'b1; ovr_mode = m; ovr_cycles = d;
    @(negedge clk); ovr_valid = 1'b0;
  endtask

  task automatic wait_drain(input int limit, input string tag);
    for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: every output transition must match the next expected item
  initial begin
    logic [6:0] prev, cur, e;
    prev = 7'd0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cur = {mode, req, lrst};
        if (cur != prev) begin
          n_chk++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R6 R7 R8 R9 R10 unexpected transition actual=%h expected=none", cur);
          end else begin
            e = exp_q.pop_front();
            if (e != cur) begin
              n_fail++;
              $display("FAIL R6 R7 R9 R10 transition actual=%h expected=%h", cur, e);
            end
          end
        end
        prev = cur;
      end
    end
  end

  // automatic done responder
  initial begin
    forever begin
      @(negedge clk);
      if (auto_en && req != 3'b0 && auto_done == 3'b0) begin
        repeat (2) @(negedge clk);
        auto_done = req;
        @(negedge clk);
        auto_done = 3'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mode == 3'd0, "R1 mode in reset", mode, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mode == 3'd0, "R1 mode", mode, 0);
    chk(req == 3'b0, "R1 req", req, 0);
    chk(lrst == 1'b0, "R1 lockstep reset", lrst, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(ovr_act == 1'b0, "R1 override", ovr_act, 0);

    // R11 illegal override code ignored
    send_ovr(3'd5, 16'd20);
    repeat (3) @(negedge clk);
    chk(ovr_act == 1'b0, "R11 illegal code active", ovr_act, 0);
    chk(mode == 3'd0, "R11 illegal code mode", mode, 0);

    // R4 boundary: count equal to upper limit does nothing
    auto_en = 1'b1;
    repeat (3) pulse_upset();
    repeat (20) @(negedge clk);
    chk(mode == 3'd0, "R4 count equal to limit", mode, 0);
    // R4 R6 R9: one more upset climbs level by level
    push_up(0);
    pulse_upset();
    wait_drain(200, "R4 R6 R9 escalation");
    repeat (40) @(negedge clk);
    chk(mode == 3'd4, "R3 upsets still in window", mode, 4);
    // R3 R5 R10: upsets age out, mode decays without reset pulses
    push_down();
    wait_drain(600, "R3 R5 R10 de-escalation");
    chk(mode == 3'd0, "R5 back to bottom", mode, 0);

    // R7 R8 R11: override to triplex, done returned per region
    auto_en = 1'b0;
    expect_t(3'd0, 3'b111, 1'b0);
    send_ovr(3'd4, 16'd300);
    repeat (3) @(negedge clk);
    chk(ovr_act == 1'b1, "R11 override active", ovr_act, 1);
    chk(busy == 1'b1, "R7 switch pending", busy, 1);
    send_ovr(3'd2, 16'd5); // ignored while pending (R8)
    expect_t(3'd0, 3'b110, 1'b0);
    @(negedge clk); man_done = 3'b001;
    @(negedge clk); man_done = 3'b000;
    repeat (3) @(negedge clk);
    chk(mode == 3'd0, "R7 mode held after partial done", mode, 0);
    expect_t(3'd4, 3'b000, 1'b1);
    expect_t(3'd4, 3'b000, 1'b0);
    @(negedge clk); man_done = 3'b110;
    @(negedge clk); man_done = 3'b000;
    repeat (100) @(negedge clk);
    chk(mode == 3'd4, "R8 R11 forced mode held", mode, 4);
    chk(ovr_act == 1'b1, "R11 override still active", ovr_act, 1);
    // R12: on expiry the empty window walks the mode down
    push_down();
    auto_en = 1'b1;
    wait_drain(600, "R12 resume after override");
    chk(ovr_act == 1'b0, "R12 override ended", ovr_act, 0);

    // R11 R12: override holds a low mode while upsets pile up
    expect_t(3'd1, 3'b000, 1'b0);
    send_ovr(3'd1, 16'd60);
    repeat (4) pulse_upset();
    repeat (20) @(negedge clk);
    chk(mode == 3'd1, "R11 policy suppressed", mode, 1);
    push_up(1);
    push_down();
    wait_drain(900, "R12 adaptive resumes with stored count");
    chk(mode == 3'd0, "R12 final mode", mode, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 no pending expectations", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule